// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter Bank

This block decides whether a received CAN identifier is of interest to the node and where it should go. It holds a bank of programmable filters. Each filter has its own reference identifier, an enable bit, a pointer to one of a small set of shared masks, and a destination FIFO number. A lookup takes the 11-bit base identifier, the 18-bit identifier extension and the frame's extended-format flag. One clock later the block returns a hit flag, the index of the winning filter and that filter's destination FIFO. Bus acknowledgement does not depend on this result, so the block has no ACK output.

The filters, masks and filter-control entries are written through three plain register write ports. A write changes the stored entry on the next clock edge. The lookup input is a valid-qualified stream with no ready signal. The block accepts one identifier in every cycle, so it never applies back-pressure. The result stream is a one-cycle `res_valid` pulse with no ready signal either, and the consumer must take it in the cycle it appears.

An entry in the filter table and in the mask table is packed as {base id[10:0], extended bit, extension[17:0]}. The base id sits in bits 29:19, the extended bit in bit 18 and the extension in bits 17:0. A filter-control entry is {enable, mask select[1:0], fifo[4:0]}. The enable is bit 7, the mask select is bits 6:5 and the fifo number is bits 4:0.

Top module: `can_accept_filter`

## Requirements
- R1: After reset, `res_valid` and `res_hit` are 0 and every filter-control entry is cleared, so a lookup made before any write reports a miss.
- R2: For each base-id bit where the selected mask holds 1, the identifier bit must equal the filter bit. Where the mask holds 0, that bit is ignored.
- R3: For an extended frame (`id_ext`=1), the extension bits are compared under the mask in the same way as the base id. For a standard frame, the extension bits are ignored.
- R4: When mask bit 18 is 1, the filter's bit 18 must equal `id_ext`. When mask bit 18 is 0, the frame format does not affect the match.
- R5: `res_valid` is high in exactly the cycle after each cycle in which `id_valid` is high. Back-to-back lookups each give their own result.
- R6: A filter whose enable bit (control bit 7) is 0 never matches. When no enabled filter matches, `res_hit`, `res_index` and `res_fifo` are all 0.
- R7: When several enabled filters match, the lowest-numbered one wins. `res_index` gives its number and `res_fifo` gives its control bits 4:0.
- R8: Each filter is compared using the mask that its control bits 6:5 select, out of the four masks.
- R9: A write takes effect for lookups presented in later cycles. A lookup presented in the same cycle as a write sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_we | input | 1 | Filter entry write strobe |
| flt_addr | input | 5 | Filter number to write |
| flt_wdata | input | 30 | Filter entry {base id, extended bit, extension} |
| msk_we | input | 1 | Mask write strobe |
| msk_addr | input | 2 | Mask number to write |
| msk_wdata | input | 30 | Mask entry {base id mask, format-match bit, extension mask} |
| ctl_we | input | 1 | Filter-control write strobe |
| ctl_addr | input | 5 | Filter number whose control entry is written |
| ctl_wdata | input | 8 | Control entry {enable, mask select, fifo} |
| id_valid | input | 1 | Lookup request qualifier |
| id_sid | input | 11 | Received base identifier |
| id_eid | input | 18 | Received identifier extension |
| id_ext | input | 1 | Received frame is in extended format |
| res_valid | output | 1 | Result present, one cycle after `id_valid` |
| res_hit | output | 1 | An enabled filter matched |
| res_index | output | 5 | Number of the winning filter |
| res_fifo | output | 5 | Destination FIFO of the winning filter |

## Verification
Every lookup result is due on the first rising edge after the cycle in which `id_valid` is driven. Inputs change on the falling edge, and the bench reads the outputs on the next falling edge, half a period after that rising edge. This also holds for streams of consecutive lookups: each falling edge both checks the previous result and presents the next identifier. A configuration write is checked the same way: it is driven on a falling edge, and lookups from the following falling edge onward must reflect it. A lookup driven together with a write must still see the old contents.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;
  localparam int DEF_NUM_FLT = 32;
  localparam int DEF_NUM_MSK = 4;
  localparam int DEF_SID_W   = 11;
  localparam int DEF_EID_W   = 18;
  localparam int DEF_FIFO_W  = 5;
endpackage

// File: rtl/can_filt_cfg.sv
module can_filt_cfg #(
  parameter int NUM_FLT = can_filt_pkg::DEF_NUM_FLT,
  parameter int NUM_MSK = can_filt_pkg::DEF_NUM_MSK,
  parameter int ENT_W   = 30,
  parameter int CTL_W   = 8,
  localparam int IDX_W  = $clog2(NUM_FLT),
  localparam int MSEL_W = $clog2(NUM_MSK)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             flt_we,
  input  logic [IDX_W-1:0]                 flt_addr,
  input  logic [ENT_W-1:0]                 flt_wdata,
  input  logic                             msk_we,
  input  logic [MSEL_W-1:0]                msk_addr,
  input  logic [ENT_W-1:0]                 msk_wdata,
  input  logic                             ctl_we,
  input  logic [IDX_W-1:0]                 ctl_addr,
  input  logic [CTL_W-1:0]                 ctl_wdata,
  output logic [NUM_FLT-1:0][ENT_W-1:0]    flt_arr,
  output logic [NUM_MSK-1:0][ENT_W-1:0]    msk_arr,
  output logic [NUM_FLT-1:0][CTL_W-1:0]    ctl_arr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flt_arr <= '0;
      msk_arr <= '0;
      ctl_arr <= '0;
    end else begin
      if (flt_we) flt_arr[flt_addr] <= flt_wdata;
      if (msk_we) msk_arr[msk_addr] <= msk_wdata;
      if (ctl_we) ctl_arr[ctl_addr] <= ctl_wdata;
    end
  end

  // R9: a control write is visible on the following cycle
  a_r9_ctl_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> ctl_arr[$past(ctl_addr)] == $past(ctl_wdata));
  a_r9_msk_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    msk_we |=> msk_arr[$past(msk_addr)] == $past(msk_wdata));
endmodule

// File: rtl/can_filt_cmp.sv
module can_filt_cmp #(
  parameter int SID_W = can_filt_pkg::DEF_SID_W,
  parameter int EID_W = can_filt_pkg::DEF_EID_W,
  localparam int ENT_W = SID_W + 1 + EID_W
) (
  input  logic             en,
  input  logic [ENT_W-1:0] flt_ent,
  input  logic [ENT_W-1:0] msk_ent,
  input  logic [SID_W-1:0] id_sid,
  input  logic [EID_W-1:0] id_eid,
  input  logic             id_ext,
  output logic             match
);
  logic [SID_W-1:0] sid_diff;
  logic [EID_W-1:0] eid_diff;
  logic             sid_ok, eid_ok, fmt_ok;

  always_comb begin
    sid_diff = (id_sid ^ flt_ent[ENT_W-1 -: SID_W]) & msk_ent[ENT_W-1 -: SID_W];
    eid_diff = (id_eid ^ flt_ent[EID_W-1:0]) & msk_ent[EID_W-1:0];
    sid_ok   = (sid_diff == '0);
    eid_ok   = !id_ext || (eid_diff == '0);
    fmt_ok   = !msk_ent[EID_W] || (flt_ent[EID_W] == id_ext);
    match    = en && sid_ok && eid_ok && fmt_ok;
  end
endmodule

// File: rtl/can_filt_prio.sv
module can_filt_prio #(
  parameter int N = can_filt_pkg::DEF_NUM_FLT,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter #(
  parameter int NUM_FLT = can_filt_pkg::DEF_NUM_FLT,
  parameter int NUM_MSK = can_filt_pkg::DEF_NUM_MSK,
  parameter int SID_W   = can_filt_pkg::DEF_SID_W,
  parameter int EID_W   = can_filt_pkg::DEF_EID_W,
  parameter int FIFO_W  = can_filt_pkg::DEF_FIFO_W,
  localparam int IDX_W  = $clog2(NUM_FLT),
  localparam int MSEL_W = $clog2(NUM_MSK),
  localparam int ENT_W  = SID_W + 1 + EID_W,
  localparam int CTL_W  = 1 + MSEL_W + FIFO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flt_we,
  input  logic [IDX_W-1:0]  flt_addr,
  input  logic [ENT_W-1:0]  flt_wdata,
  input  logic              msk_we,
  input  logic [MSEL_W-1:0] msk_addr,
  input  logic [ENT_W-1:0]  msk_wdata,
  input  logic              ctl_we,
  input  logic [IDX_W-1:0]  ctl_addr,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic              id_valid,
  input  logic [SID_W-1:0]  id_sid,
  input  logic [EID_W-1:0]  id_eid,
  input  logic              id_ext,
  output logic              res_valid,
  output logic              res_hit,
  output logic [IDX_W-1:0]  res_index,
  output logic [FIFO_W-1:0] res_fifo
);
  logic [NUM_FLT-1:0][ENT_W-1:0] flt_arr;
  logic [NUM_MSK-1:0][ENT_W-1:0] msk_arr;
  logic [NUM_FLT-1:0][CTL_W-1:0] ctl_arr;
  logic [NUM_FLT-1:0]            match_vec;
  logic                          pe_hit;
  logic [IDX_W-1:0]              pe_idx;
  logic [FIFO_W-1:0]             fifo_sel;

  can_filt_cfg #(
    .NUM_FLT(NUM_FLT), .NUM_MSK(NUM_MSK), .ENT_W(ENT_W), .CTL_W(CTL_W)
  ) cfg_i (
    .clk(clk), .rst_n(rst_n),
    .flt_we(flt_we), .flt_addr(flt_addr), .flt_wdata(flt_wdata),
    .msk_we(msk_we), .msk_addr(msk_addr), .msk_wdata(msk_wdata),
    .ctl_we(ctl_we), .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata),
    .flt_arr(flt_arr), .msk_arr(msk_arr), .ctl_arr(ctl_arr)
  );

  for (genvar g = 0; g < NUM_FLT; g++) begin : g_flt
    logic [MSEL_W-1:0] msel;
    assign msel = ctl_arr[g][CTL_W-2 -: MSEL_W];
    can_filt_cmp #(.SID_W(SID_W), .EID_W(EID_W)) cmp_i (
      .en(ctl_arr[g][CTL_W-1]),
      .flt_ent(flt_arr[g]),
      .msk_ent(msk_arr[msel]),
      .id_sid(id_sid), .id_eid(id_eid), .id_ext(id_ext),
      .match(match_vec[g])
    );
  end

  can_filt_prio #(.N(NUM_FLT)) prio_i (
    .req(match_vec), .hit(pe_hit), .idx(pe_idx)
  );

  assign fifo_sel = pe_hit ? ctl_arr[pe_idx][FIFO_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_index <= '0;
      res_fifo  <= '0;
    end else begin
      res_valid <= id_valid;
      res_hit   <= id_valid && pe_hit;
      res_index <= (id_valid && pe_hit) ? pe_idx : '0;
      res_fifo  <= id_valid ? fifo_sel : '0;
    end
  end

  logic [NUM_FLT-1:0] below_mask;
  assign below_mask = (NUM_FLT'(1) << pe_idx) - NUM_FLT'(1);

  a_r5_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |=> res_valid);
  a_r5_pulse_ends: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |=> !res_valid);
  a_r6_hit_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> res_valid);
  a_r6_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_index == '0 && res_fifo == '0));
  a_r6_no_false_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && !pe_hit) |-> (match_vec == '0));
  a_r7_winner_matches: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && pe_hit) |-> match_vec[pe_idx]);
  a_r7_none_lower: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && pe_hit) |-> ((match_vec & below_mask) == '0));
endmodule

// File: tb/can_accept_filter_tb.sv
module can_accept_filter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flt_we = 1'b0, msk_we = 1'b0, ctl_we = 1'b0;
  logic [4:0]  flt_addr = '0, ctl_addr = '0;
  logic [1:0]  msk_addr = '0;
  logic [29:0] flt_wdata = '0, msk_wdata = '0;
  logic [7:0]  ctl_wdata = '0;
  logic        id_valid = 1'b0, id_ext = 1'b0;
  logic [10:0] id_sid = '0;
  logic [17:0] id_eid = '0;
  logic        res_valid, res_hit;
  logic [4:0]  res_index, res_fifo;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [29:0] m_flt [32];
  logic [29:0] m_msk [4];
  logic [7:0]  m_ctl [32];

  always #5 clk = ~clk;

  can_accept_filter dut_i (
    .clk(clk), .rst_n(rst_n),
    .flt_we(flt_we), .flt_addr(flt_addr), .flt_wdata(flt_wdata),
    .msk_we(msk_we), .msk_addr(msk_addr), .msk_wdata(msk_wdata),
    .ctl_we(ctl_we), .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata),
    .id_valid(id_valid), .id_sid(id_sid), .id_eid(id_eid), .id_ext(id_ext),
    .res_valid(res_valid), .res_hit(res_hit),
    .res_index(res_index), .res_fifo(res_fifo)
  );

  // expected {hit, index, fifo} from the requirement rules
  function automatic logic [10:0] model(input logic [10:0] s, input logic [17:0] e,
                                        input logic x);
    for (int i = 0; i < 32; i++) begin
      logic [29:0] f, m;
      bit ok;
      f  = m_flt[i];
      m  = m_msk[m_ctl[i][6:5]];
      ok = m_ctl[i][7];
      if (((s ^ f[29:19]) & m[29:19]) != 0) ok = 0;
      if (x && (((e ^ f[17:0]) & m[17:0]) != 0)) ok = 0;
      if (m[18] && (f[18] != x)) ok = 0;
      if (ok) return {1'b1, 5'(i), m_ctl[i][4:0]};
    end
    return '0;
  endfunction

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_flt(input int a, input logic [29:0] d);
    @(negedge clk); flt_we = 1; flt_addr = 5'(a); flt_wdata = d;
    @(negedge clk); flt_we = 0; m_flt[a] = d;
  endtask
  task automatic wr_msk(input int a, input logic [29:0] d);
    @(negedge clk); msk_we = 1; msk_addr = 2'(a); msk_wdata = d;
    @(negedge clk); msk_we = 0; m_msk[a] = d;
  endtask
  task automatic wr_ctl(input int a, input logic [7:0] d);
    @(negedge clk); ctl_we = 1; ctl_addr = 5'(a); ctl_wdata = d;
    @(negedge clk); ctl_we = 0; m_ctl[a] = d;
  endtask

  // called at a falling edge; leaves id_valid high for chaining
  task automatic lookup(input string req, input logic [10:0] s, input logic [17:0] e,
                        input logic x);
    logic [10:0] exp;
    exp = model(s, e, x);
    id_valid = 1; id_sid = s; id_eid = e; id_ext = x;
    @(negedge clk);
    check(req, {res_valid, res_hit, res_index, res_fifo}, {1'b1, exp});
  endtask

  task automatic idle();
    id_valid = 0;
    @(negedge clk);
    check("R5", {11'd0, res_valid}, 12'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 32; i++) begin m_flt[i] = '0; m_ctl[i] = '0; end
    for (int i = 0; i < 4; i++) m_msk[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1", {10'd0, res_valid, res_hit}, 12'd0);
    @(negedge clk);
    lookup("R1", 11'h123, 18'h0, 0);  // all disabled: miss
    idle();

    // R2/R3/R4: exact mask 0 on filter 5
    wr_msk(0, {11'h7FF, 1'b1, 18'h3FFFF});
    wr_flt(5, {11'h123, 1'b0, 18'h0});
    wr_ctl(5, {1'b1, 2'd0, 5'd9});
    @(negedge clk);
    lookup("R3", 11'h123, 18'h2AAAA, 0); // std ignores EID: hit 5 fifo 9
    lookup("R2", 11'h122, 18'h0, 0);     // one bit off: miss
    lookup("R4", 11'h123, 18'h0, 1);     // format differs: miss
    idle();

    // R2/R8: mask 1 ignores low SID bits and frame format
    wr_msk(1, {11'h7F8, 1'b0, 18'h3FFFF});
    wr_flt(9, {11'h450, 1'b1, 18'h01234});
    wr_ctl(9, {1'b1, 2'd1, 5'd3});
    @(negedge clk);
    lookup("R2", 11'h457, 18'h01234, 1); // hit 9
    lookup("R3", 11'h457, 18'h01235, 1); // EID mismatch: miss
    lookup("R4", 11'h455, 18'h3FFFF, 0); // std, format ignored: hit 9
    idle();

    // R7 priority, R6 disable
    wr_flt(2, {11'h450, 1'b0, 18'h01234});
    wr_ctl(2, {1'b1, 2'd1, 5'd7});
    @(negedge clk);
    lookup("R7", 11'h457, 18'h01234, 1); // hit 2 fifo 7
    idle();
    wr_ctl(2, {1'b0, 2'd1, 5'd7});
    @(negedge clk);
    lookup("R6", 11'h457, 18'h01234, 1); // hit 9
    idle();

    // R8: filter 9 moved to exact mask 0
    wr_ctl(9, {1'b1, 2'd0, 5'd3});
    @(negedge clk);
    lookup("R8", 11'h457, 18'h01234, 1); // miss
    lookup("R8", 11'h450, 18'h01234, 1); // hit 9
    idle();

    // R9: lookup in the same cycle as a disabling write sees old entry
    @(negedge clk);
    ctl_we = 1; ctl_addr = 5'd9; ctl_wdata = 8'h03;
    lookup("R9", 11'h450, 18'h01234, 1); // old: hit 9
    ctl_we = 0; m_ctl[9] = 8'h03;
    lookup("R9", 11'h450, 18'h01234, 1); // now miss
    idle();

    // random configuration and back-to-back random lookups
    for (int i = 0; i < 32; i++) begin
      wr_flt(i, 30'($urandom));
      wr_ctl(i, {1'($urandom_range(0, 3) != 0), 2'($urandom), 5'($urandom)});
    end
    wr_msk(0, 30'h3FFFFFFF);
    wr_msk(1, {11'h7FF, 1'b0, 18'h0});
    wr_msk(2, 30'($urandom));
    wr_msk(3, 30'($urandom) & 30'h0FF7FFFF);
    @(negedge clk);
    for (int k = 0; k < 400; k++) begin
      logic [29:0] base, flip;
      int f;
      f    = $urandom_range(0, 31);
      base = m_flt[f];
      flip = ($urandom_range(0, 3) == 0) ? 30'($urandom) : (30'($urandom) & ~m_msk[m_ctl[f][6:5]]);
      base = base ^ flip;
      lookup("R7", base[29:19], base[17:0], base[18]);
      if ($urandom_range(0, 7) == 0) idle();
    end
    idle();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule